// File: doc/BRIEF.md
# Program Permission Guard with Write-Enable Latch and Region Lock

This block sits behind the instruction decoder of a serial nonvolatile memory. It decides, cycle by cycle, whether a program operation may begin. It keeps a write-enable latch, a program-busy flag and a two-bit region-lock code. It compares the target address of a data write against the locked upper region of the array. When a start pulse is accepted, `prog_grant` rises in the same cycle and the program engine begins its cycle. The engine later reports completion with `prog_done`.

Two decoded pulses control the latch: `wren_pls` sets it and `wrdi_pls` clears it. The latch also clears by itself when a granted program cycle ends, so every program needs a fresh enable. The lock code is held in ordinary flops. It changes only through a granted status write, which takes its new value from `bp_wdata`. The decoder has already extracted that two-bit field from the status byte it received. The latch, busy flag and lock code drive the status register that the host reads back.

Top module: `wel_bp_guard`

## Requirements
- R1: After reset, `wel` is 0, `busy` is 0 and `bp` is 2'b00.
- R2: While idle and with no start granted in the same cycle, `wrdi_pls` clears `wel` at the next edge and `wren_pls` sets it. When both pulses arrive together, clearing wins.
- R3: `prog_done` while `busy` is 1 clears both `busy` and `wel` at the next edge. `prog_done` while idle has no effect.
- R4: `prog_grant` is 1 only when `wp_pin` is 1, `wel` is 1 and `busy` is 0, and it is combinational from the start pulse in the same cycle.
- R5: The lock code selects the locked range of a data write (`wr_start`): 2'b00 locks nothing, 2'b01 locks 0x600 to 0x7FF, 2'b10 locks 0x400 to 0x7FF, and 2'b11 locks 0x000 to 0x7FF.
- R6: A data write to a locked address gets no grant. It does not set `busy` and it leaves `wel` unchanged.
- R7: While `busy` is 1, `wren_pls` and `wrdi_pls` are ignored and no start is granted.
- R8: `bp` loads `bp_wdata` only at the edge that ends a cycle with a granted status write (`wrsr_start`). A refused status write leaves `bp` unchanged, and nothing else writes `wel` or `busy` directly.
- R9: A status write is not checked against the locked range, so it is granted even when the lock code is 2'b11.
- R10: A granted start sets `busy` at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wren_pls | input | 1 | Decoded write-enable instruction pulse |
| wrdi_pls | input | 1 | Decoded write-disable instruction pulse |
| wr_start | input | 1 | Request to start a data program cycle |
| wrsr_start | input | 1 | Request to start a status program cycle |
| prog_done | input | 1 | Program engine reports the current cycle finished |
| tgt_addr | input | ADDR_W (11) | Target byte address of a data write |
| wp_pin | input | 1 | Write-protect pin; 1 allows programming |
| bp_wdata | input | 2 | New lock code carried by a status write |
| prog_grant | output | 1 | Start accepted in this cycle |
| wel | output | 1 | Write-enable latch state |
| busy | output | 1 | Program cycle in progress |
| bp | output | 2 | Current region-lock code |

## Verification
`prog_grant` is combinational, so it is due in the same cycle as the start pulse. The bench compares it a few nanoseconds after the falling edge where the inputs were driven, before the next rising edge. `wel`, `busy` and `bp` change at the first rising edge after their cause and are compared one falling edge later. After reset is released, the outputs hold their reset values until the internal release stages finish. The bench covers that window with idle cycles whose expected values are the reset state. The driver updates its own model only after it has queued the expected item for a cycle, so each comparison uses the state from before that cycle's edge.

// File: rtl/wel_bp_pkg.sv
package wel_bp_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_lvl_e;

endpackage

// File: rtl/rst_release.sv
module rst_release #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/wel_latch_ctrl.sv
module wel_latch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic start_ok,
  input  logic done,
  output logic wel_q,
  output logic busy_q
);

  logic wel_d;
  logic busy_d;
  logic st_en;

  // next-state: busy phase owns the latch until completion
  always_comb begin
    wel_d  = wel_q;
    busy_d = busy_q;
    st_en  = 1'b0;
    if (busy_q) begin
      if (done) begin
        wel_d  = 1'b0;
        busy_d = 1'b0;
        st_en  = 1'b1;
      end
    end else if (start_ok) begin
      busy_d = 1'b1;
      st_en  = 1'b1;
    end else if (clr_req) begin
      wel_d  = 1'b0;
      st_en  = 1'b1;
    end else if (set_req) begin
      wel_d  = 1'b1;
      st_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (st_en) begin
      wel_q  <= wel_d;
      busy_q <= busy_d;
    end
  end

endmodule

// File: rtl/bp_zone_reg.sv
module bp_zone_reg
  import wel_bp_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [1:0]        load_val,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        bp_q,
  output logic              addr_locked
);

  localparam int          SPAN       = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(SPAN / 2);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(SPAN - SPAN / 4);

  lock_lvl_e lvl;
  logic [1:0] bp_d;

  assign lvl = lock_lvl_e'(bp_q);

  always_comb begin
    unique case (lvl)
      LOCK_NONE:    addr_locked = 1'b0;
      LOCK_QUARTER: addr_locked = (addr >= QTR_BASE);
      LOCK_HALF:    addr_locked = (addr >= HALF_BASE);
      LOCK_ALL:     addr_locked = 1'b1;
      default:      addr_locked = 1'b1;
    endcase
  end

  always_comb begin
    bp_d = bp_q;
    if (load_en) bp_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bp_q <= 2'b00;
    else if (load_en) bp_q <= bp_d;
  end

endmodule

// File: rtl/wel_bp_guard.sv
module wel_bp_guard #(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_pls,
  input  logic              wrdi_pls,
  input  logic              wr_start,
  input  logic              wrsr_start,
  input  logic              prog_done,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              wp_pin,
  input  logic [1:0]        bp_wdata,
  output logic              prog_grant,
  output logic              wel,
  output logic              busy,
  output logic [1:0]        bp
);

  logic rst_q_n;
  logic addr_locked;
  logic may_prog;
  logic data_ok;
  logic stat_ok;

  rst_release #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // permission: pin, latch and idle engine gate both start kinds
  assign may_prog   = wp_pin & wel & ~busy;
  assign data_ok    = may_prog & wr_start & ~addr_locked;
  assign stat_ok    = may_prog & wrsr_start;
  assign prog_grant = data_ok | stat_ok;

  wel_latch_ctrl u_latch (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .set_req  (wren_pls),
    .clr_req  (wrdi_pls),
    .start_ok (prog_grant),
    .done     (prog_done),
    .wel_q    (wel),
    .busy_q   (busy)
  );

  bp_zone_reg #(.ADDR_W(ADDR_W)) u_zone (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .load_en     (stat_ok),
    .load_val    (bp_wdata),
    .addr        (tgt_addr),
    .bp_q        (bp),
    .addr_locked (addr_locked)
  );

endmodule

// File: rtl/wel_bp_guard_chk.sv
module wel_bp_guard_chk (
  input logic       clk,
  input logic       rst_q_n,
  input logic       wren_pls,
  input logic       wrdi_pls,
  input logic       wr_start,
  input logic       wrsr_start,
  input logic       prog_done,
  input logic       wp_pin,
  input logic       prog_grant,
  input logic       wel,
  input logic       busy,
  input logic [1:0] bp
);

  AST_WREN_SETS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && !prog_grant && wren_pls && !wrdi_pls) |=> wel); // R2

  AST_WRDI_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && !prog_grant && wrdi_pls) |=> !wel); // R2

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && prog_done) |=> (!wel && !busy)); // R3

  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rst_q_n)
    prog_grant |-> (wp_pin && wel && !busy)); // R4

  AST_FULL_LOCK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bp == 2'b11 && wr_start && !wrsr_start) |-> !prog_grant); // R5

  AST_BUSY_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && !prog_done) |=> (busy && $stable(wel))); // R7

  AST_BP_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(prog_grant && wrsr_start) |=> $stable(bp)); // R8

  AST_GRANT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_q_n)
    prog_grant |=> busy); // R10

endmodule

bind wel_bp_guard wel_bp_guard_chk u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .wren_pls   (wren_pls),
  .wrdi_pls   (wrdi_pls),
  .wr_start   (wr_start),
  .wrsr_start (wrsr_start),
  .prog_done  (prog_done),
  .wp_pin     (wp_pin),
  .prog_grant (prog_grant),
  .wel        (wel),
  .busy       (busy),
  .bp         (bp)
);

// File: tb/wel_bp_guard_tb.sv
`timescale 1ns/1ps
module wel_bp_guard_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wren_pls, wrdi_pls, wr_start, wrsr_start, prog_done, wp_pin;
  logic [10:0] tgt_addr;
  logic [1:0]  bp_wdata;
  logic        prog_grant, wel, busy;
  logic [1:0]  bp;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  wel_bp_guard u_dut (
    .clk(clk), .rst_n(rst_n), .wren_pls(wren_pls), .wrdi_pls(wrdi_pls),
    .wr_start(wr_start), .wrsr_start(wrsr_start), .prog_done(prog_done),
    .tgt_addr(tgt_addr), .wp_pin(wp_pin), .bp_wdata(bp_wdata),
    .prog_grant(prog_grant), .wel(wel), .busy(busy), .bp(bp)
  );

  typedef struct {
    logic       g;
    logic       w;
    logic       b;
    logic [1:0] p;
    string      tag;
  } exp_t;

  exp_t exp_q[$];

  // reference model state
  logic       m_wel, m_busy;
  logic [1:0] m_bp;

  function automatic logic locked(input logic [1:0] lv, input logic [10:0] a);
    case (lv)
      2'b00:   return 1'b0;
      2'b01:   return a >= 11'h600;
      2'b10:   return a >= 11'h400;
      default: return 1'b1;
    endcase
  endfunction

  task automatic cyc(input logic en, input logic dis, input logic wr, input logic sr,
                     input logic dn, input logic wp, input logic [10:0] a,
                     input logic [1:0] d, input string tag);
    exp_t e;
    logic g;
    @(negedge clk);
    wren_pls = en; wrdi_pls = dis; wr_start = wr; wrsr_start = sr;
    prog_done = dn; wp_pin = wp; tgt_addr = a; bp_wdata = d;
    g = !m_busy && wp && m_wel && ((wr && !locked(m_bp, a)) || sr);
    e.g = g; e.w = m_wel; e.b = m_busy; e.p = m_bp; e.tag = tag;
    exp_q.push_back(e);
    if (m_busy) begin
      if (dn) begin m_busy = 1'b0; m_wel = 1'b0; end
    end else if (g) begin
      m_busy = 1'b1;
      if (sr && wp && m_wel) m_bp = d;
    end else if (dis) m_wel = 1'b0;
    else if (en) m_wel = 1'b1;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 1, 11'h000, 2'b00, tag);
  endtask

  // monitor: compare each queued item between the driving and the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (prog_grant !== e.g || wel !== e.w || busy !== e.b || bp !== e.p) begin
          fails++;
          $display("FAIL %s: grant/wel/busy/bp actual %b/%b/%b/%b expected %b/%b/%b/%b",
                   e.tag, prog_grant, wel, busy, bp, e.g, e.w, e.b, e.p);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_wel = 0; m_busy = 0; m_bp = 2'b00;
    rst_n = 0; wren_pls = 0; wrdi_pls = 0; wr_start = 0; wrsr_start = 0;
    prog_done = 0; wp_pin = 1; tgt_addr = '0; bp_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) idle("R1 reset state");
    // R4: no latch, no grant; R4 pin low blocks; R6 latch kept
    cyc(0, 0, 1, 0, 0, 1, 11'h000, 2'b00, "R4 no latch");
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 1, 0, 0, 0, 11'h000, 2'b00, "R4 pin low");
    idle("R6 latch kept after pin refusal");
    // R8 status write to quarter lock, R10 busy next edge
    cyc(0, 0, 0, 1, 0, 1, 11'h000, 2'b01, "R8 status write");
    cyc(0, 1, 0, 0, 0, 1, 11'h000, 2'b00, "R7 wrdi ignored busy");
    cyc(0, 0, 1, 0, 0, 1, 11'h000, 2'b00, "R7 no grant busy");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 done");
    idle("R3 latch cleared");
    // R8 refused status write keeps bp
    cyc(0, 0, 0, 1, 0, 1, 11'h000, 2'b11, "R8 refused status");
    idle("R8 bp unchanged");
    // quarter lock boundaries
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 1, 0, 0, 1, 11'h600, 2'b00, "R5 R6 0x600 locked q");
    cyc(0, 0, 1, 0, 0, 1, 11'h5FF, 2'b00, "R5 0x5FF open q");
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R7 wren ignored busy");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 done");
    // half lock
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 0, 1, 0, 1, 11'h000, 2'b10, "R8 status half");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 done");
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 1, 0, 0, 1, 11'h400, 2'b00, "R5 0x400 locked h");
    cyc(0, 0, 1, 0, 0, 1, 11'h3FF, 2'b00, "R5 0x3FF open h");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 done");
    // full lock, status write still allowed
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 0, 1, 0, 1, 11'h000, 2'b11, "R8 status all");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 done");
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 1, 0, 0, 1, 11'h000, 2'b00, "R5 0x000 locked all");
    cyc(0, 0, 0, 1, 0, 1, 11'h000, 2'b00, "R9 status under full lock");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 done");
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 1, 0, 0, 1, 11'h7FF, 2'b00, "R5 0x7FF open none");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 done");
    // both pulses, stray done
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(1, 1, 0, 0, 0, 1, 11'h000, 2'b00, "R2 both pulses");
    cyc(1, 0, 0, 0, 0, 1, 11'h000, 2'b00, "R2 wren");
    cyc(0, 0, 0, 0, 1, 1, 11'h000, 2'b00, "R3 idle done ignored");
    idle("R3 latch kept after idle done");
    idle("final");
    @(negedge clk);
    #5;
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule